// File: doc/BRIEF.md
# Tagged Operand Prefetch Buffer with Store Queue

This block sits between an instruction decode stage and a single memory port. Decode hands it effective operand addresses, and each one is held in one of six slots. The block sends a tagged read to memory for each slot, and the tag is the slot number. Memory may answer the reads in any order. Each answer is steered by its tag into the data register of its own slot. The execute stage takes operands back in the order decode supplied them, and a slot becomes free only after its data has been taken.

Alongside the prefetch slots sits a four-entry store queue. A store is accepted in a single cycle and the processor never waits for a memory reply. Queued stores drain to memory in arrival order. When a prefetch read and a store both want the memory port, the read always wins. A reply that names a slot not waiting for data is discarded, and an error flag is pulsed.

Top module: `opnd_prefetch_buf`

## Requirements
- R1: `pfReqReady` is high exactly when fewer than six prefetch slots are allocated. A request presented while it is low is not taken.
- R2: Slots are allocated in ring order 0,1,…,5,0. Reads are issued in allocation order, with `memReqTag` equal to the slot index (0..5) and `memReqAddr` equal to the address captured for that slot.
- R3: A reply whose tag names a slot with a read outstanding writes `memRspData` into that slot. Replies may come in any order.
- R4: `exValid` is high when the oldest allocated slot holds its data, with `exData` equal to that data and `exTag` equal to its index. A younger filled slot is never presented first. The outputs hold steady until `exTake` is asserted, and the slot is then freed.
- R5: `stReqReady` is high exactly when the store queue holds fewer than four entries. A store presented while it is high is taken in that cycle, and one presented while it is low is dropped.
- R6: Queued stores leave in arrival order, with `memReqWrite`=1, their own address on `memReqAddr` and their own data on `memReqData`.
- R7: While any allocated slot has not yet issued its read, the port presents that read (`memReqWrite`=0), even if stores are queued.
- R8: A reply whose tag is 6 or 7, or names a slot that is not awaiting data, raises `rspErr` for exactly the next cycle. Its data is discarded and no slot changes.
- R9: After reset no slot is allocated, the store queue is empty, `memReqValid`, `exValid` and `rspErr` are low, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfReqValid | input | 1 | Decode offers an operand address |
| pfReqAddr | input | ADDR_W | Effective operand address |
| pfReqReady | output | 1 | A prefetch slot is free |
| exValid | output | 1 | Oldest slot's operand is present |
| exTag | output | TAG_W | Slot index of the presented operand |
| exData | output | DATA_W | Presented operand data |
| exTake | input | 1 | Execute consumes the presented operand |
| stReqValid | input | 1 | A store is offered |
| stReqAddr | input | ADDR_W | Store address |
| stReqData | input | DATA_W | Store data |
| stReqReady | output | 1 | Store queue has room |
| memReqValid | output | 1 | Memory request present |
| memReqWrite | output | 1 | 1 = store, 0 = tagged read |
| memReqTag | output | TAG_W | Slot tag of a read (0 for a store) |
| memReqAddr | output | ADDR_W | Request address |
| memReqData | output | DATA_W | Store data (0 for a read) |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memRspValid | input | 1 | Read reply present |
| memRspTag | input | TAG_W | Tag returned unchanged with the reply |
| memRspData | input | DATA_W | Read reply data |
| rspErr | output | 1 | One-cycle pulse for a reply nobody awaits |

## Verification
Every result has a fixed latency. A slot or store accepted at an edge changes the ready outputs and the memory request right after that same edge. A read reply shows on `exValid`/`exData` just after the edge that captures it. `rspErr` is registered, so it rises just after the edge where the bad reply was seen and falls one edge later. The bench drives inputs 1 ns after a rising edge and samples at that point, before the next edge, so each check looks at the cycle that follows the stimulating edge. Three different reply orders are swept over a full set of six slots, to show that fill order never changes the order of consumption.

// File: rtl/opb_pkg.sv
package opb_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE,
    SLOT_QUEUED,
    SLOT_INFLIGHT,
    SLOT_FILLED
  } slotState_e;

  typedef struct packed {
    logic allocEn;
    logic fillEn;
    logic sqPush;
  } opbStrobe_t;

endpackage

// File: rtl/opb_ctrl.sv
module opb_ctrl
  import opb_pkg::*;
#(
  parameter int SLOTS    = 6,
  parameter int SQ_DEPTH = 4,
  localparam int TAG_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int SQ_AW   = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfReqValid,
  output logic             pfReqReady,
  input  logic             stReqValid,
  output logic             stReqReady,
  input  logic             memReqReady,
  output logic             memReqValid,
  output logic             memReqWrite,
  input  logic             memRspValid,
  input  logic [TAG_W-1:0] memRspTag,
  input  logic             exTake,
  output logic             exValid,
  output logic             rspErr,
  output opbStrobe_t       strobe,
  output logic [TAG_W-1:0] allocIdx,
  output logic [TAG_W-1:0] issueIdx,
  output logic [TAG_W-1:0] headIdx,
  output logic [SQ_AW-1:0] sqWrIdx,
  output logic [SQ_AW-1:0] sqRdIdx
);

  localparam logic [TAG_W:0] SLOT_LIM = (TAG_W+1)'(SLOTS);
  localparam logic [SQ_AW:0] SQ_LIM   = (SQ_AW+1)'(SQ_DEPTH);

  slotState_e       slotState [SLOTS];
  logic [TAG_W:0]   slotCnt;
  logic [SQ_AW:0]   sqCnt;
  logic             allocFire, loadPending, loadFire, storeFire, stFire;
  logic             consume, fillHit;

  function automatic logic [TAG_W-1:0] nextSlot(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(SLOTS-1)) ? '0 : p + TAG_W'(1);
  endfunction

  function automatic logic [SQ_AW-1:0] nextSq(input logic [SQ_AW-1:0] p);
    return (p == SQ_AW'(SQ_DEPTH-1)) ? '0 : p + SQ_AW'(1);
  endfunction

  assign pfReqReady  = slotCnt < SLOT_LIM;
  assign stReqReady  = sqCnt < SQ_LIM;
  assign allocFire   = pfReqValid && pfReqReady;
  assign stFire      = stReqValid && stReqReady;
  assign loadPending = slotState[issueIdx] == SLOT_QUEUED;
  assign memReqValid = loadPending || (sqCnt != '0);
  assign memReqWrite = !loadPending && (sqCnt != '0);
  assign loadFire    = loadPending && memReqReady;
  assign storeFire   = memReqWrite && memReqReady;
  assign exValid     = slotState[headIdx] == SLOT_FILLED;
  assign consume     = exValid && exTake;

  always_comb begin
    fillHit = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (memRspValid && memRspTag == TAG_W'(i) && slotState[i] == SLOT_INFLIGHT)
        fillHit = 1'b1;
  end

  always_comb begin
    strobe.allocEn = allocFire;
    strobe.fillEn  = fillHit;
    strobe.sqPush  = stFire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slotState[i] <= SLOT_FREE;
      allocIdx <= '0;
      issueIdx <= '0;
      headIdx  <= '0;
      slotCnt  <= '0;
      sqWrIdx  <= '0;
      sqRdIdx  <= '0;
      sqCnt    <= '0;
      rspErr   <= 1'b0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (allocFire && allocIdx == TAG_W'(i))
          slotState[i] <= SLOT_QUEUED;
        else if (loadFire && issueIdx == TAG_W'(i))
          slotState[i] <= SLOT_INFLIGHT;
        else if (fillHit && memRspTag == TAG_W'(i))
          slotState[i] <= SLOT_FILLED;
        else if (consume && headIdx == TAG_W'(i))
          slotState[i] <= SLOT_FREE;
      end
      if (allocFire) allocIdx <= nextSlot(allocIdx);
      if (loadFire)  issueIdx <= nextSlot(issueIdx);
      if (consume)   headIdx  <= nextSlot(headIdx);
      case ({allocFire, consume})
        2'b10:   slotCnt <= slotCnt + (TAG_W+1)'(1);
        2'b01:   slotCnt <= slotCnt - (TAG_W+1)'(1);
        default: slotCnt <= slotCnt;
      endcase
      if (stFire)    sqWrIdx <= nextSq(sqWrIdx);
      if (storeFire) sqRdIdx <= nextSq(sqRdIdx);
      case ({stFire, storeFire})
        2'b10:   sqCnt <= sqCnt + (SQ_AW+1)'(1);
        2'b01:   sqCnt <= sqCnt - (SQ_AW+1)'(1);
        default: sqCnt <= sqCnt;
      endcase
      rspErr <= memRspValid && !fillHit;
    end
  end

endmodule

// File: rtl/opb_datapath.sv
module opb_datapath
  import opb_pkg::*;
#(
  parameter int SLOTS    = 6,
  parameter int SQ_DEPTH = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  localparam int TAG_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int SQ_AW   = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  opbStrobe_t        strobe,
  input  logic [TAG_W-1:0]  allocIdx,
  input  logic [ADDR_W-1:0] pfAddr,
  input  logic [TAG_W-1:0]  fillIdx,
  input  logic [DATA_W-1:0] fillData,
  input  logic [SQ_AW-1:0]  sqWrIdx,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [TAG_W-1:0]  issueIdx,
  input  logic [TAG_W-1:0]  headIdx,
  input  logic [SQ_AW-1:0]  sqRdIdx,
  output logic [ADDR_W-1:0] issueAddr,
  output logic [DATA_W-1:0] headData,
  output logic [ADDR_W-1:0] sqHeadAddr,
  output logic [DATA_W-1:0] sqHeadData
);

  logic [ADDR_W-1:0] slotAddr [SLOTS];
  logic [DATA_W-1:0] slotData [SLOTS];
  logic [ADDR_W-1:0] sqAddr   [SQ_DEPTH];
  logic [DATA_W-1:0] sqData   [SQ_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        slotAddr[i] <= '0;
        slotData[i] <= '0;
      end
      for (int j = 0; j < SQ_DEPTH; j++) begin
        sqAddr[j] <= '0;
        sqData[j] <= '0;
      end
    end else begin
      if (strobe.allocEn) slotAddr[allocIdx] <= pfAddr;
      if (strobe.fillEn)  slotData[fillIdx]  <= fillData;
      if (strobe.sqPush) begin
        sqAddr[sqWrIdx] <= stAddr;
        sqData[sqWrIdx] <= stData;
      end
    end
  end

  assign issueAddr  = slotAddr[issueIdx];
  assign headData   = slotData[headIdx];
  assign sqHeadAddr = sqAddr[sqRdIdx];
  assign sqHeadData = sqData[sqRdIdx];

endmodule

// File: rtl/opnd_prefetch_buf.sv
module opnd_prefetch_buf
  import opb_pkg::*;
#(
  parameter int SLOTS    = 6,
  parameter int SQ_DEPTH = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  localparam int TAG_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfReqValid,
  input  logic [ADDR_W-1:0] pfReqAddr,
  output logic              pfReqReady,
  output logic              exValid,
  output logic [TAG_W-1:0]  exTag,
  output logic [DATA_W-1:0] exData,
  input  logic              exTake,
  input  logic              stReqValid,
  input  logic [ADDR_W-1:0] stReqAddr,
  input  logic [DATA_W-1:0] stReqData,
  output logic              stReqReady,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [TAG_W-1:0]  memReqTag,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [TAG_W-1:0]  memRspTag,
  input  logic [DATA_W-1:0] memRspData,
  output logic              rspErr
);

  localparam int SQ_AW = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1;

  opbStrobe_t        strobe;
  logic [TAG_W-1:0]  allocIdx, issueIdx, headIdx;
  logic [SQ_AW-1:0]  sqWrIdx, sqRdIdx;
  logic [ADDR_W-1:0] issueAddr, sqHeadAddr;
  logic [DATA_W-1:0] sqHeadData;

  opb_ctrl #(.SLOTS(SLOTS), .SQ_DEPTH(SQ_DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .pfReqValid(pfReqValid), .pfReqReady(pfReqReady),
    .stReqValid(stReqValid), .stReqReady(stReqReady),
    .memReqReady(memReqReady), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memRspValid(memRspValid), .memRspTag(memRspTag),
    .exTake(exTake), .exValid(exValid), .rspErr(rspErr),
    .strobe(strobe), .allocIdx(allocIdx), .issueIdx(issueIdx), .headIdx(headIdx),
    .sqWrIdx(sqWrIdx), .sqRdIdx(sqRdIdx)
  );

  opb_datapath #(.SLOTS(SLOTS), .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .allocIdx(allocIdx), .pfAddr(pfReqAddr),
    .fillIdx(memRspTag), .fillData(memRspData),
    .sqWrIdx(sqWrIdx), .stAddr(stReqAddr), .stData(stReqData),
    .issueIdx(issueIdx), .headIdx(headIdx), .sqRdIdx(sqRdIdx),
    .issueAddr(issueAddr), .headData(exData),
    .sqHeadAddr(sqHeadAddr), .sqHeadData(sqHeadData)
  );

  assign exTag      = headIdx;
  assign memReqTag  = memReqWrite ? '0 : issueIdx;
  assign memReqAddr = memReqWrite ? sqHeadAddr : issueAddr;
  assign memReqData = memReqWrite ? sqHeadData : '0;

endmodule

// File: rtl/opb_checker.sv
module opb_checker #(
  parameter int SLOTS    = 6,
  parameter int SQ_DEPTH = 4,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  localparam int TAG_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pfReqValid,
  input logic [ADDR_W-1:0] pfReqAddr,
  input logic              pfReqReady,
  input logic              exValid,
  input logic [TAG_W-1:0]  exTag,
  input logic [DATA_W-1:0] exData,
  input logic              exTake,
  input logic              stReqValid,
  input logic [ADDR_W-1:0] stReqAddr,
  input logic [DATA_W-1:0] stReqData,
  input logic              stReqReady,
  input logic              memReqValid,
  input logic              memReqWrite,
  input logic [TAG_W-1:0]  memReqTag,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqData,
  input logic              memReqReady,
  input logic              memRspValid,
  input logic [TAG_W-1:0]  memRspTag,
  input logic [DATA_W-1:0] memRspData,
  input logic              rspErr
);

  logic [7:0] occSlots, unissued, occSq;
  logic       aFire, cFire, lFire, sFire, wFire;

  assign aFire = pfReqValid && pfReqReady;
  assign cFire = exValid && exTake;
  assign lFire = memReqValid && !memReqWrite && memReqReady;
  assign sFire = stReqValid && stReqReady;
  assign wFire = memReqValid && memReqWrite && memReqReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occSlots <= '0;
      unissued <= '0;
      occSq    <= '0;
    end else begin
      occSlots <= occSlots + 8'(aFire) - 8'(cFire);
      unissued <= unissued + 8'(aFire) - 8'(lFire);
      occSq    <= occSq + 8'(sFire) - 8'(wFire);
    end
  end

  AST_SLOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pfReqReady == (occSlots < 8'(SLOTS))); // R1
  AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqWrite) |-> ({1'b0, memReqTag} < (TAG_W+1)'(SLOTS))); // R2
  AST_EX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exValid && !exTake) |=> (exValid && $stable(exData) && $stable(exTag))); // R4
  AST_SQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stReqReady == (occSq < 8'(SQ_DEPTH))); // R5
  AST_NO_PHANTOM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (occSq == 8'd0) |-> !(memReqValid && memReqWrite)); // R6
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (unissued != 8'd0) |-> (memReqValid && !memReqWrite)); // R7
  AST_BAD_TAG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (memRspValid && ({1'b0, memRspTag} >= (TAG_W+1)'(SLOTS))) |=> rspErr); // R8

endmodule

bind opnd_prefetch_buf opb_checker #(
  .SLOTS(SLOTS), .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/opnd_prefetch_buf_tb_top.sv
`timescale 1ns/1ps
module opnd_prefetch_buf_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pfReqValid, pfReqReady, exValid, exTake;
  logic [15:0] pfReqAddr, exData, stReqAddr, stReqData, memReqAddr, memReqData, memRspData;
  logic [2:0]  exTag, memReqTag, memRspTag;
  logic        stReqValid, stReqReady, memReqValid, memReqWrite, memReqReady;
  logic        memRspValid, rspErr;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  int nextSlot = 0;

  always #4 clk = ~clk;

  opnd_prefetch_buf dut_i (.*);

  function automatic logic [15:0] expData(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic respond(input logic [2:0] tag, input logic [15:0] data);
    memRspValid = 1'b1;
    memRspTag   = tag;
    memRspData  = data;
    tick();
    memRspValid = 1'b0;
  endtask

  task automatic runRound(input int variant, input logic [15:0] base);
    logic [15:0] addrs [6];
    bit filled [6];
    int s0 = nextSlot;
    memReqReady = 1'b0;
    for (int i = 0; i < 6; i++) begin
      addrs[i] = base + 16'(i * 7);
      filled[i] = 1'b0;
      chk("R1", "ready before alloc", pfReqReady, 1);
      pfReqValid = 1'b1;
      pfReqAddr  = addrs[i];
      tick();
    end
    chk("R1", "ready when six allocated", pfReqReady, 0);
    pfReqAddr = 16'hFFFF;
    tick();
    pfReqValid = 1'b0;
    nextSlot = (nextSlot + 6) % 6;
    memReqReady = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chk("R2", "load valid", memReqValid, 1);
      chk("R2", "load is read", memReqWrite, 0);
      chk("R2", "load tag", memReqTag, (s0 + i) % 6);
      chk("R2", "load addr", memReqAddr, addrs[i]);
      tick();
    end
    chk("R2", "no seventh load", memReqValid, 0);
    memReqReady = 1'b0;
    for (int k = 0; k < 6; k++) begin
      int p;
      case (variant)
        0: p = k;
        1: p = 5 - k;
        default: p = (k < 3) ? 2 * k + 1 : 2 * (k - 3);
      endcase
      chk("R4", "head presented only when oldest filled", exValid, filled[0]);
      respond(3'((s0 + p) % 6), expData(addrs[p]));
      filled[p] = 1'b1;
      chk("R3", "no error on good reply", rspErr, 0);
    end
    tick();
    chk("R4", "held head data", exData, expData(addrs[0]));
    for (int i = 0; i < 6; i++) begin
      chk("R4", "exValid in order", exValid, 1);
      chk("R4", "exTag in order", exTag, (s0 + i) % 6);
      chk("R3", "filled data", exData, expData(addrs[i]));
      exTake = 1'b1;
      tick();
      exTake = 1'b0;
    end
    chk("R4", "all consumed", exValid, 0);
    chk("R1", "ready after drain", pfReqReady, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    pfReqValid = 0; pfReqAddr = 0; exTake = 0;
    stReqValid = 0; stReqAddr = 0; stReqData = 0;
    memReqReady = 0; memRspValid = 0; memRspTag = 0; memRspData = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R9", "pfReqReady", pfReqReady, 1);
    chk("R9", "stReqReady", stReqReady, 1);
    chk("R9", "memReqValid", memReqValid, 0);
    chk("R9", "exValid", exValid, 0);
    chk("R9", "rspErr", rspErr, 0);

    runRound(0, 16'h0100);
    runRound(1, 16'h0200);
    runRound(2, 16'h0300);

    respond(3'd7, 16'hBAD0);
    chk("R8", "error on tag 7", rspErr, 1);
    tick();
    chk("R8", "error lasts one cycle", rspErr, 0);
    respond(3'd2, 16'hBAD1);
    chk("R8", "error on free slot", rspErr, 1);
    chk("R8", "free slot not filled", exValid, 0);
    tick();
    memReqReady = 1'b0;
    pfReqValid = 1'b1; pfReqAddr = 16'h0555;
    tick();
    pfReqValid = 1'b0;
    respond(3'(nextSlot), 16'hBAD2);
    chk("R8", "error on unissued slot", rspErr, 1);
    chk("R8", "unissued slot not filled", exValid, 0);
    memReqReady = 1'b1;
    chk("R2", "late load addr", memReqAddr, 16'h0555);
    tick();
    memReqReady = 1'b0;
    respond(3'(nextSlot), expData(16'h0555));
    chk("R8", "bad data discarded", exData, expData(16'h0555));
    exTake = 1'b1; tick(); exTake = 1'b0;
    nextSlot = (nextSlot + 1) % 6;

    for (int i = 0; i < 4; i++) begin
      chk("R5", "store ready with room", stReqReady, 1);
      stReqValid = 1'b1;
      stReqAddr  = 16'h0400 + 16'(i);
      stReqData  = 16'h1000 * 16'(i + 1);
      tick();
    end
    chk("R5", "store ready when full", stReqReady, 0);
    chk("R6", "head store shown", memReqAddr, 16'h0400);
    stReqAddr = 16'hDEAD;
    tick();
    stReqValid = 1'b0;
    pfReqValid = 1'b1; pfReqAddr = 16'h0777;
    tick();
    pfReqValid = 1'b0;
    chk("R7", "load beats stores", memReqWrite, 0);
    chk("R7", "load addr over stores", memReqAddr, 16'h0777);
    memReqReady = 1'b1;
    tick();
    for (int i = 0; i < 4; i++) begin
      chk("R6", "store write", memReqWrite, 1);
      chk("R6", "store addr", memReqAddr, 16'h0400 + 16'(i));
      chk("R6", "store data", memReqData, 16'h1000 * 16'(i + 1));
      tick();
    end
    chk("R5", "store while full dropped", memReqValid, 0);
    memReqReady = 1'b0;
    respond(3'(nextSlot), expData(16'h0777));
    chk("R3", "fill after stores", exData, expData(16'h0777));
    exTake = 1'b1; tick(); exTake = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule